// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block is the control state machine in front of a four-input sampling converter. It decides which input is active and for how long the front end stays in each phase: power-up, sample, then convert. It does this from a 1 µs time base and a 6-bit operating-mode code. Software writes the mode code with a strobe. The sequencer then converts one selected input or sweeps all inputs in ascending order, either once or forever. At the end of every convert phase it raises a one-clock result-valid strobe. The strobe carries the index of the input just converted, so the result can be captured beside it.

Phase lengths are set by two 5-bit codes:

- The power-up phase lasts twice its code in microseconds. It is inserted only on the first conversion after the block leaves its idle mode.
- The sample phase lasts six microseconds plus twice its code.
- The convert phase is a fixed four microseconds.

Mode changes follow a handshake. A direct jump from one converting mode to another is refused. The awake mode must be written in between.

States:

- ST_IDLE: powered down.
- ST_AWAKE: powered, not converting.
- ST_PWRUP
- ST_SAMPLE
- ST_CONV

Transitions:

- Idle/awake to PWRUP: start, when power-up is pending and its code is non-zero.
- Idle/awake to SAMPLE: start, otherwise.
- PWRUP to SAMPLE: power-up time elapsed.
- SAMPLE to CONV: sample time elapsed.
- CONV to SAMPLE: a further input or a repeat is due.
- CONV to AWAKE: a one-shot mode is finished.
- Any state to IDLE: an idle write.
- Any state to AWAKE: an awake write.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the reported mode is 0x00 (idle), no phase output is high and the done strobe is low.
- R2: Only these 6-bit codes are accepted: 0x00 idle, 0x20 awake, 0x30 one-shot single, 0x31 repeating single, 0x32 one-shot sweep, 0x33 repeating sweep, 0x39 repeating single with sleep, 0x3B repeating sweep with sleep, 0x3F burst with sleep. A write of any other code leaves the mode and all outputs unchanged.
- R3: The power-up phase lasts 2×(power-up code) ticks. It occurs only for the first conversion after leaving idle, whether or not awake was written in between. A code of 0 omits it.
- R4: The sample phase lasts 2×(sample code)+6 ticks, from 6 up to 68 ticks.
- R5: The convert phase lasts exactly 4 ticks, and the done strobe follows only a convert phase.
- R6: A write of a converting code while a converting mode is current is ignored: the mode and the conversion in progress continue.
- R7: One-shot single converts the selected input once, then the mode becomes awake (0x20).
- R8: One-shot sweep converts inputs 0, 1, 2, 3 in that order, then the mode becomes awake.
- R9: Repeating single converts the selected input without end. Repeating sweep repeats 0..3 and wraps to 0. The sleep variants 0x39, 0x3B and 0x3F behave like repeating single, sweep and sweep respectively.
- R10: A write of idle aborts any phase. On the next clock all phase outputs are low and the mode is 0x00.
- R11: The done strobe is one clock wide and carries the index of the input whose conversion ended. The channel output is steady from sample into convert.
- R12: A write of awake during a conversion aborts it: no done strobe, no phase output, mode 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| mode_code | input | 6 | Requested operating mode |
| chan_sel | input | 2 | Input used by the single modes |
| mode_wr | input | 1 | Strobe that applies mode_code and chan_sel |
| pwrup_code | input | 5 | Power-up length code |
| acq_code | input | 5 | Sample length code |
| mode_o | output | 6 | Mode currently in force |
| chan_o | output | 2 | Active input index |
| ph_pwrup | output | 1 | Power-up phase active |
| ph_sample | output | 1 | Sample phase active |
| ph_convert | output | 1 | Convert phase active |
| done | output | 1 | One-clock result-valid strobe |
| done_chan | output | 2 | Input index belonging to done |

## Verification
The bench builds the block with its default parameters:

- four inputs;
- 5-bit timing codes;
- a 2 µs step, a 6 µs sample base and a 4 µs convert time.

The microsecond tick is one clock in four. With 5-bit codes the longest sample phase (code 31, 68 ticks) is reachable within a short one-shot sweep. The four-input setting makes the wrap from input 3 back to input 0 visible after only four conversions. Phase lengths are measured by counting the ticks seen while each phase output is high, so the checks do not depend on the tick phase at the moment of the write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam logic [5:0] MC_IDLE        = 6'h00;
    localparam logic [5:0] MC_AWAKE       = 6'h20;
    localparam logic [5:0] MC_ONE_SINGLE  = 6'h30;
    localparam logic [5:0] MC_REP_SINGLE  = 6'h31;
    localparam logic [5:0] MC_ONE_SWEEP   = 6'h32;
    localparam logic [5:0] MC_REP_SWEEP   = 6'h33;
    localparam logic [5:0] MC_SLP_SINGLE  = 6'h39;
    localparam logic [5:0] MC_SLP_SWEEP   = 6'h3B;
    localparam logic [5:0] MC_SLP_BURST   = 6'h3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AWAKE,
        ST_PWRUP,
        ST_SAMPLE,
        ST_CONV
    } seq_state_t;

    typedef enum logic [1:0] {
        SW_ONCE_ONE,
        SW_ONCE_ALL,
        SW_LOOP_ONE,
        SW_LOOP_ALL
    } sweep_t;

    typedef struct packed {
        logic   valid;
        logic   conv;
        sweep_t sweep;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [5:0] c);
        mode_info_t r;
        r.valid = 1'b0;
        r.conv  = 1'b0;
        r.sweep = SW_ONCE_ONE;
        case (c)
            MC_IDLE, MC_AWAKE: r.valid = 1'b1;
            MC_ONE_SINGLE: begin
                r.valid = 1'b1; r.conv = 1'b1; r.sweep = SW_ONCE_ONE;
            end
            MC_ONE_SWEEP: begin
                r.valid = 1'b1; r.conv = 1'b1; r.sweep = SW_ONCE_ALL;
            end
            MC_REP_SINGLE, MC_SLP_SINGLE: begin
                r.valid = 1'b1; r.conv = 1'b1; r.sweep = SW_LOOP_ONE;
            end
            MC_REP_SWEEP, MC_SLP_SWEEP, MC_SLP_BURST: begin
                r.valid = 1'b1; r.conv = 1'b1; r.sweep = SW_LOOP_ALL;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_mode_gate.sv
module adc_seq_mode_gate
    import adc_seq_pkg::*;
(
    input  logic [5:0] cur_mode,
    input  logic       wr,
    input  logic [5:0] code,
    output logic       accept,
    output mode_info_t cur_info,
    output mode_info_t new_info
);

    logic is_rest;

    always_comb begin
        cur_info = decode_mode(cur_mode);
        new_info = decode_mode(code);
        is_rest  = (code == MC_IDLE) || (code == MC_AWAKE);
        // converting modes may only be entered from idle or awake
        accept   = wr && new_info.valid && (is_rest || !cur_info.conv);
    end

endmodule

// File: rtl/adc_seq_chan_step.sv
module adc_seq_chan_step
    import adc_seq_pkg::*;
#(
    parameter int N_CH = 4,
    localparam int CW = $clog2(N_CH)
) (
    input  logic [CW-1:0] chan,
    input  sweep_t        sweep,
    output logic [CW-1:0] next_chan,
    output logic          finished
);

    logic at_top;
    logic [CW-1:0] inc_chan;

    always_comb begin
        at_top   = (chan == CW'(N_CH - 1));
        inc_chan = at_top ? '0 : chan + 1'b1;
        next_chan = chan;
        finished  = 1'b0;
        unique case (sweep)
            SW_ONCE_ONE: finished = 1'b1;
            SW_ONCE_ALL: begin
                finished  = at_top;
                next_chan = inc_chan;
            end
            SW_LOOP_ONE: next_chan = chan;
            SW_LOOP_ALL: next_chan = inc_chan;
        endcase
    end

endmodule

// File: rtl/adc_seq_phase_timer.sv
module adc_seq_phase_timer #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign expire = tick && (remain == TW'(1));

    // a phase of zero length must never be started
    assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int CODE_W      = 5,
    parameter int STEP_US     = 2,
    parameter int ACQ_BASE_US = 6,
    parameter int CONV_US     = 4,
    localparam int CW = $clog2(N_CH),
    localparam int TW = $clog2(STEP_US * (2**CODE_W - 1) + ACQ_BASE_US + CONV_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic [5:0]        mode_code,
    input  logic [CW-1:0]     chan_sel,
    input  logic              mode_wr,
    input  logic [CODE_W-1:0] pwrup_code,
    input  logic [CODE_W-1:0] acq_code,
    output logic [5:0]        mode_o,
    output logic [CW-1:0]     chan_o,
    output logic              ph_pwrup,
    output logic              ph_sample,
    output logic              ph_convert,
    output logic              done,
    output logic [CW-1:0]     done_chan
);

    seq_state_t    state_q, state_d;
    logic [5:0]    mode_q, mode_d;
    logic [CW-1:0] chan_q, chan_d;
    logic          pend_q, pend_d;
    logic          done_q, done_d;
    logic [CW-1:0] dch_q, dch_d;

    logic          accept;
    mode_info_t    cur_info, new_info;
    logic [CW-1:0] step_chan;
    logic          step_last;
    logic          t_load, t_expire;
    logic [TW-1:0] t_val;
    logic [TW-1:0] pw_len, acq_len, conv_len;

    adc_seq_mode_gate u_gate (
        .cur_mode (mode_q),
        .wr       (mode_wr),
        .code     (mode_code),
        .accept   (accept),
        .cur_info (cur_info),
        .new_info (new_info)
    );

    adc_seq_chan_step #(.N_CH(N_CH)) u_step (
        .chan      (chan_q),
        .sweep     (cur_info.sweep),
        .next_chan (step_chan),
        .finished  (step_last)
    );

    adc_seq_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .tick     (tick_us),
        .expire   (t_expire)
    );

    always_comb begin
        pw_len   = TW'(pwrup_code) * TW'(STEP_US);
        acq_len  = TW'(acq_code) * TW'(STEP_US) + TW'(ACQ_BASE_US);
        conv_len = TW'(CONV_US);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        chan_d  = chan_q;
        pend_d  = pend_q;
        done_d  = 1'b0;
        dch_d   = dch_q;
        t_load  = 1'b0;
        t_val   = conv_len;
        if (accept) begin
            mode_d = mode_code;
            if (mode_code == MC_IDLE) begin
                state_d = ST_IDLE;
                pend_d  = 1'b1;
            end else if (mode_code == MC_AWAKE) begin
                state_d = ST_AWAKE;
            end else begin
                if ((new_info.sweep == SW_ONCE_ONE) || (new_info.sweep == SW_LOOP_ONE))
                    chan_d = chan_sel;
                else
                    chan_d = '0;
                t_load = 1'b1;
                if (pend_q && (pwrup_code != '0)) begin
                    state_d = ST_PWRUP;
                    t_val   = pw_len;
                end else begin
                    state_d = ST_SAMPLE;
                    t_val   = acq_len;
                    pend_d  = 1'b0;
                end
            end
        end else begin
            unique case (state_q)
                ST_IDLE, ST_AWAKE: ;
                ST_PWRUP: if (t_expire) begin
                    state_d = ST_SAMPLE;
                    t_load  = 1'b1;
                    t_val   = acq_len;
                    pend_d  = 1'b0;
                end
                ST_SAMPLE: if (t_expire) begin
                    state_d = ST_CONV;
                    t_load  = 1'b1;
                    t_val   = conv_len;
                end
                ST_CONV: if (t_expire) begin
                    done_d = 1'b1;
                    dch_d  = chan_q;
                    if (step_last) begin
                        state_d = ST_AWAKE;
                        mode_d  = MC_AWAKE;
                    end else begin
                        chan_d  = step_chan;
                        state_d = ST_SAMPLE;
                        t_load  = 1'b1;
                        t_val   = acq_len;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MC_IDLE;
            chan_q  <= '0;
            pend_q  <= 1'b1;
            done_q  <= 1'b0;
            dch_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            chan_q  <= chan_d;
            pend_q  <= pend_d;
            done_q  <= done_d;
            dch_q   <= dch_d;
        end
    end

    // outputs
    always_comb begin
        ph_pwrup   = (state_q == ST_PWRUP);
        ph_sample  = (state_q == ST_SAMPLE);
        ph_convert = (state_q == ST_CONV);
        mode_o     = mode_q;
        chan_o     = chan_q;
        done       = done_q;
        done_chan  = dch_q;
    end

    assert_done_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_conv_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_convert) |-> ($past(ph_sample) && $stable(chan_o)));

    assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ph_convert));

    assert_idle_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (mode_code == MC_IDLE)) |=>
            (!ph_pwrup && !ph_sample && !ph_convert && (mode_o == MC_IDLE)));

    assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && cur_info.conv && new_info.conv) |=>
            ((mode_o != $past(mode_code)) || ($past(mode_o) == $past(mode_code))));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic [5:0] mode_code = 6'h00;
    logic [1:0] chan_sel = 2'd0;
    logic       mode_wr = 1'b0;
    logic [4:0] pwrup_code = 5'd0;
    logic [4:0] acq_code = 5'd0;
    logic [5:0] mode_o;
    logic [1:0] chan_o;
    logic       ph_pwrup, ph_sample, ph_convert, done;
    logic [1:0] done_chan;

    int n_chk = 0;
    int n_bad = 0;
    int pw_cnt = 0, sa_cnt = 0, cv_cnt = 0;
    int done_n = 0;
    int done_log [0:63];
    logic prev_done = 1'b0;
    int div = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .mode_code(mode_code), .chan_sel(chan_sel), .mode_wr(mode_wr),
        .pwrup_code(pwrup_code), .acq_code(acq_code),
        .mode_o(mode_o), .chan_o(chan_o),
        .ph_pwrup(ph_pwrup), .ph_sample(ph_sample), .ph_convert(ph_convert),
        .done(done), .done_chan(done_chan)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // microsecond tick: one clock in four
    always @(negedge clk) begin
        tick_us <= (div == 3);
        div <= (div + 1) % 4;
    end

    // monitor, sampled after inputs settle
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (tick_us) begin
                if (ph_pwrup)   pw_cnt++;
                if (ph_sample)  sa_cnt++;
                if (ph_convert) cv_cnt++;
            end
            if (done) begin
                check("R11 done one clock wide", int'(prev_done), 0);
                done_log[done_n % 64] = int'(done_chan);
                done_n++;
            end
            prev_done = done;
        end
    end

    task automatic wr_mode(input logic [5:0] code, input logic [1:0] ch);
        @(negedge clk);
        mode_code = code;
        chan_sel  = ch;
        mode_wr   = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
        #2;
    endtask

    task automatic wait_dones(input int target);
        int guard = 0;
        while (done_n < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        #2;
    endtask

    task automatic wait_clocks(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic t_reset;
        check("R1 mode after reset", int'(mode_o), 'h00);
        check("R1 phases after reset", int'({ph_pwrup, ph_sample, ph_convert}), 0);
        check("R1 done after reset", int'(done), 0);
    endtask

    // R7 from idle, with power-up (R3), minimum sample (R4), convert (R5)
    task automatic t_single_from_idle;
        int p0 = pw_cnt, s0 = sa_cnt, c0 = cv_cnt, d0 = done_n;
        pwrup_code = 5'd3; acq_code = 5'd0;
        wr_mode(6'h30, 2'd2);
        wait_dones(d0 + 1);
        wait_clocks(2);
        check("R3 power-up ticks code 3", pw_cnt - p0, 6);
        check("R4 sample ticks code 0", sa_cnt - s0, 6);
        check("R5 convert ticks", cv_cnt - c0, 4);
        check("R7 one done", done_n - d0, 1);
        check("R11 done channel", done_log[d0 % 64], 2);
        check("R7 mode back to awake", int'(mode_o), 'h20);
    endtask

    // R3: no power-up when starting from awake
    task automatic t_single_from_awake;
        int p0 = pw_cnt, s0 = sa_cnt, d0 = done_n;
        acq_code = 5'd5;
        wr_mode(6'h30, 2'd1);
        wait_dones(d0 + 1);
        wait_clocks(2);
        check("R3 no power-up from awake", pw_cnt - p0, 0);
        check("R4 sample ticks code 5", sa_cnt - s0, 16);
        check("R7 done channel", done_log[d0 % 64], 1);
    endtask

    task automatic t_one_sweep_max;
        int s0 = sa_cnt, c0 = cv_cnt, d0 = done_n;
        acq_code = 5'd31;
        wr_mode(6'h32, 2'd3);
        wait_dones(d0 + 4);
        wait_clocks(3);
        check("R4 sample ticks code 31 x4", sa_cnt - s0, 272);
        check("R5 convert ticks x4", cv_cnt - c0, 16);
        for (int i = 0; i < 4; i++)
            check("R8 sweep order", done_log[(d0 + i) % 64], i);
        check("R8 stops after 4", done_n - d0, 4);
        check("R8 mode back to awake", int'(mode_o), 'h20);
    endtask

    task automatic t_skip_pwrup;
        int p0, d0;
        wr_mode(6'h00, 2'd0);
        pwrup_code = 5'd0; acq_code = 5'd0;
        p0 = pw_cnt; d0 = done_n;
        wr_mode(6'h30, 2'd3);
        wait_dones(d0 + 1);
        check("R3 code 0 skips power-up", pw_cnt - p0, 0);
        check("R7 done channel 3", done_log[d0 % 64], 3);
    endtask

    task automatic t_rep_sweep_ignore_idle;
        int d0 = done_n;
        wr_mode(6'h33, 2'd2);
        wait_dones(d0 + 6);
        for (int i = 0; i < 6; i++)
            check("R9 repeating sweep order", done_log[(d0 + i) % 64], i % 4);
        wr_mode(6'h30, 2'd1);
        check("R6 mode unchanged", int'(mode_o), 'h33);
        wait_dones(d0 + 8);
        check("R6 sweep continues ch2", done_log[(d0 + 6) % 64], 2);
        check("R6 sweep continues ch3", done_log[(d0 + 7) % 64], 3);
        wait_clocks(9);
        wr_mode(6'h00, 2'd0);
        check("R10 phases cleared", int'({ph_pwrup, ph_sample, ph_convert}), 0);
        check("R10 mode idle", int'(mode_o), 'h00);
    endtask

    task automatic t_rep_single_abort;
        int p0, d0, d1, guard;
        pwrup_code = 5'd4; acq_code = 5'd1;
        wr_mode(6'h20, 2'd0);
        p0 = pw_cnt; d0 = done_n;
        wr_mode(6'h31, 2'd1);
        wait_dones(d0 + 3);
        check("R3 power-up after idle then awake", pw_cnt - p0, 8);
        for (int i = 0; i < 3; i++)
            check("R9 repeating single channel", done_log[(d0 + i) % 64], 1);
        guard = 0;
        while (!ph_sample && guard < 2000) begin @(negedge clk); #2; guard++; end
        while (!ph_convert && guard < 2000) begin @(negedge clk); #2; guard++; end
        wr_mode(6'h20, 2'd0);
        d1 = done_n;
        check("R12 mode awake", int'(mode_o), 'h20);
        check("R12 phases cleared", int'({ph_pwrup, ph_sample, ph_convert}), 0);
        wait_clocks(100);
        check("R12 no done after abort", done_n - d1, 0);
    endtask

    task automatic t_sleep_variants;
        int d0 = done_n;
        acq_code = 5'd0;
        wr_mode(6'h3F, 2'd2);
        wait_dones(d0 + 5);
        for (int i = 0; i < 5; i++)
            check("R9 burst acts as sweep", done_log[(d0 + i) % 64], i % 4);
        wr_mode(6'h20, 2'd0);
        d0 = done_n;
        wr_mode(6'h39, 2'd2);
        check("R2 sleep single accepted", int'(mode_o), 'h39);
        wait_dones(d0 + 2);
        check("R9 sleep single ch", done_log[d0 % 64], 2);
        check("R9 sleep single repeats", done_log[(d0 + 1) % 64], 2);
        wr_mode(6'h20, 2'd0);
    endtask

    task automatic t_invalid;
        int d0 = done_n;
        wr_mode(6'h15, 2'd0);
        check("R2 invalid code ignored", int'(mode_o), 'h20);
        wait_clocks(60);
        check("R2 no phase after invalid", int'({ph_pwrup, ph_sample, ph_convert}), 0);
        check("R2 no done after invalid", done_n - d0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_single_from_idle();
        t_single_from_awake();
        t_one_sweep_max();
        t_skip_pwrup();
        t_rep_sweep_ignore_idle();
        t_rep_single_abort();
        t_sleep_variants();
        t_invalid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule